// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This unit gathers the fourteen interrupt sources of a UART transceiver and its FIFOs into one sticky status register. Short event strobes (line errors, overrun, underrun, CTS change, receive timeout, break completion, bus error) set their status bit directly. FIFO level conditions set their bit on the rising edge of the condition. Software acknowledges events by writing ones to the status register, and the usual handler writes back the value it has just read. An enable register with the same bit layout gates the status onto one active-high, level-sensitive interrupt line.

The register port is a one-bit select, a write strobe, write data and a combinational read data bus. Select 0 addresses the enable register and select 1 addresses the status register. The block generates no events of its own: every FIFO threshold and line condition arrives on an input.

Source bit map (the same in both registers): 0 transmit holding empty, 1 receive holding full, 2 TX FIFO almost empty, 3 TX FIFO empty, 4 RX FIFO almost full, 5 RX FIFO full, 6 TX underrun, 7 RX overrun, 8 parity error, 9 framing error, 10 CTS changed, 11 receive timeout, 12 break finished, 13 bus error response.

Top module: `isr_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the status and enable registers, which also forces irq low.
- R2: A 1 on ev_pulse[i] at a clock edge sets status bit i after that edge. The bit then stays set until software clears it.
- R3: Bits 0 to 5 are level-type. Each sets on a clock edge where lvl_cond[i] is 1 and was 0 at the previous edge, so a held condition does not set the bit again after it is cleared. lvl_cond bits 6 to 13 have no effect.
- R4: A write with reg_sel=1 clears every status bit whose reg_wdata bit is 1 and leaves every other status bit unchanged.
- R5: If a bit's set source and its clear arrive at the same edge, the bit ends up set.
- R6: Status bits latch whether or not their enable bit is 1.
- R7: A write with reg_sel=0 loads reg_wdata into the enable register. reg_rdata shows the enable register when reg_sel=0 and the status register when reg_sel=1.
- R8: irq is 1 exactly when some bit is 1 in both the status and enable registers. An all-zero enable value masks every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects enable register, 1 selects status register |
| reg_wdata | input | 14 | Write data: enable value, or clear mask for status |
| reg_rdata | output | 14 | Read data of the selected register |
| ev_pulse | input | 14 | One-cycle event strobes, one per source bit |
| lvl_cond | input | 14 | Level conditions; only bits 0 to 5 are used |
| irq | output | 1 | Active-high level interrupt |

## Verification
Several properties are checked on every cycle. No status bit falls except through a status write. No bit rises without a strobe or a level condition. A strobe always wins over a simultaneous clear. The enable register changes only when it is written. irq always matches the AND-OR of the two registers. Only the bench's scenarios can show the rest: the exact bit positions, edge-only setting for held level conditions, that the upper condition inputs are ignored, and that partial clear masks act bit by bit. The bench sweeps every source bit against zero, one-hot and inverted enable masks.

// File: rtl/isr_pkg.sv
// Package: shared constants for the UART interrupt status unit.
// Assumes: fourteen sources; bit positions are fixed by the status layout.
package isr_pkg;
    localparam int unsigned ISR_NUM_SRC = 14;

    // Source bit positions.
    localparam int unsigned SRC_TX_HOLD_EMPTY = 0;
    localparam int unsigned SRC_RX_HOLD_FULL  = 1;
    localparam int unsigned SRC_TXF_LOW       = 2;
    localparam int unsigned SRC_TXF_EMPTY     = 3;
    localparam int unsigned SRC_RXF_HIGH      = 4;
    localparam int unsigned SRC_RXF_FULL      = 5;
    localparam int unsigned SRC_TX_UNDERRUN   = 6;
    localparam int unsigned SRC_RX_OVERRUN    = 7;
    localparam int unsigned SRC_PARITY_ERR    = 8;
    localparam int unsigned SRC_FRAME_ERR     = 9;
    localparam int unsigned SRC_CTS_CHANGE    = 10;
    localparam int unsigned SRC_RX_TIMEOUT    = 11;
    localparam int unsigned SRC_BREAK_DONE    = 12;
    localparam int unsigned SRC_BUS_ERR       = 13;

    // Sources driven by level conditions (the FIFO and holding-register levels).
    localparam logic [ISR_NUM_SRC-1:0] ISR_LEVEL_MASK =
        ISR_NUM_SRC'((1 << (SRC_RXF_FULL + 1)) - 1);

    // Register select encoding.
    localparam logic SEL_ENABLE = 1'b0;
    localparam logic SEL_STATUS = 1'b1;
endpackage

// File: rtl/isr_level_rise.sv
// Module: rising-edge detector for the level-type sources.
// Assumes: LVL_MASK marks which bits are level-type; other bits yield 0.
module isr_level_rise #(
    parameter int unsigned          NUM_SRC  = 14,
    parameter logic [NUM_SRC-1:0]   LVL_MASK = 14'h003F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl_i,
    output logic [NUM_SRC-1:0] rise_o
);
    logic unused_lvl;

    // Sink the inputs of non-level bits.
    assign unused_lvl = ^(lvl_i & ~LVL_MASK);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (LVL_MASK[i]) begin : g_level
            logic prev_q;

            // Remember the condition seen at the previous edge.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= lvl_i[i];
            end

            // Flag a low-to-high transition.
            assign rise_o[i] = lvl_i[i] & ~prev_q;
        end else begin : g_event
            assign rise_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/isr_status_reg.sv
// Module: sticky status register with write-one-to-clear.
// Assumes: set_i has priority over clr_i on the same edge.
module isr_status_reg #(
    parameter int unsigned NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] status_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // Per-bit sticky flag: reset, then set, then clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        status_o[i] <= 1'b0;
            else if (set_i[i]) status_o[i] <= 1'b1;
            else if (clr_i[i]) status_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/isr_enable_reg.sv
// Module: enable mask register, loaded whole on a write.
// Assumes: wr_i is a single-cycle qualified write strobe.
module isr_enable_reg #(
    parameter int unsigned NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] enable_o
);
    // Hold the mask; replace it on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    enable_o <= '0;
        else if (wr_i) enable_o <= wdata_i;
    end
endmodule

// File: rtl/isr_irq_gen.sv
// Module: combines status and enable into a single level interrupt.
// Assumes: both inputs come straight from registers.
module isr_irq_gen #(
    parameter int unsigned NUM_SRC = 14
) (
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic               irq_o
);
    // Raise the line while any enabled source is pending.
    always_comb irq_o = |(status_i & enable_i);
endmodule

// File: rtl/isr_unit.sv
// Module: top of the UART interrupt status and enable unit.
// Assumes: reg_wr is qualified by reg_sel; reads are combinational.
module isr_unit #(
    parameter int unsigned        NUM_SRC  = isr_pkg::ISR_NUM_SRC,
    parameter logic [NUM_SRC-1:0] LVL_MASK = isr_pkg::ISR_LEVEL_MASK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] ev_pulse,
    input  logic [NUM_SRC-1:0] lvl_cond,
    output logic               irq
);
    logic [NUM_SRC-1:0] lvl_rise;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic               wr_status;
    logic               wr_enable;

    // Decode the register writes.
    assign wr_status = reg_wr & (reg_sel == isr_pkg::SEL_STATUS);
    assign wr_enable = reg_wr & (reg_sel == isr_pkg::SEL_ENABLE);

    // Merge strobes with level rises; form the clear mask.
    assign set_vec = ev_pulse | lvl_rise;
    assign clr_vec = wr_status ? reg_wdata : '0;

    isr_level_rise #(.NUM_SRC(NUM_SRC), .LVL_MASK(LVL_MASK)) u_rise (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_cond), .rise_o(lvl_rise)
    );

    isr_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
        .status_o(status_q)
    );

    isr_enable_reg #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_enable), .wdata_i(reg_wdata),
        .enable_o(enable_q)
    );

    isr_irq_gen #(.NUM_SRC(NUM_SRC)) u_irq (
        .status_i(status_q), .enable_i(enable_q), .irq_o(irq)
    );

    // Select the register to read.
    always_comb reg_rdata = (reg_sel == isr_pkg::SEL_STATUS) ? status_q : enable_q;
endmodule

// File: rtl/isr_unit_chk.sv
// Checker: cycle properties of the interrupt status unit, bound to the top.
module isr_unit_chk #(
    parameter int unsigned        NUM_SRC  = 14,
    parameter logic [NUM_SRC-1:0] LVL_MASK = 14'h003F
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic               reg_sel,
    input logic [NUM_SRC-1:0] ev_pulse,
    input logic [NUM_SRC-1:0] lvl_cond,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic               irq
);
    logic in_reset_q = 1'b0;

    // Note that the previous edge was a reset edge.
    always_ff @(posedge clk) in_reset_q <= !rst_n;

    // R1: the registers read zero right after a reset edge.
    always @(negedge clk) begin
        if (in_reset_q) begin
            a_r1_reset_clear: assert (status_q == '0 && enable_q == '0 && !irq);
        end
    end

    // R2: without a status write, no pending bit falls.
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R3: a bit rises only from a strobe or a level-type condition.
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((status_q & ~$past(status_q) & ~$past(ev_pulse)
                    & ~$past(lvl_cond & LVL_MASK)) == '0));

    // R5: a strobe always lands, even against a clear.
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse != '0) |=> ((status_q & $past(ev_pulse)) == $past(ev_pulse)));

    // R7: the enable register changes only on an enable write.
    a_r7_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && !reg_sel) |=> $stable(enable_q));

    // R8: the interrupt line tracks the masked status.
    a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((status_q & enable_q) != '0));
endmodule

bind isr_unit isr_unit_chk #(.NUM_SRC(NUM_SRC), .LVL_MASK(LVL_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .ev_pulse(ev_pulse), .lvl_cond(lvl_cond), .status_q(status_q),
    .enable_q(enable_q), .irq(irq)
);

// File: tb/isr_unit_tb.sv
module isr_unit_tb;
    localparam int unsigned N     = 14;
    localparam int unsigned CLK_P = 10;
    localparam logic [N-1:0] LVLM = 14'h003F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic         reg_sel = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic [N-1:0] ev_pulse = '0;
    logic [N-1:0] lvl_cond = '0;
    logic         irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [N-1:0] exp_st = '0;
    logic [N-1:0] exp_en = '0;
    logic [N-1:0] prev_lvl = '0;

    always #(CLK_P/2) clk = ~clk;

    isr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev_pulse),
        .lvl_cond(lvl_cond), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Read both registers and irq through the ports, between edges.
    task automatic check_all(input string tag);
        reg_wr = 1'b0;
        ev_pulse = '0;
        reg_sel = 1'b0; #1;
        chk(tag, "enable", reg_rdata, exp_en);
        reg_sel = 1'b1; #1;
        chk(tag, "status", reg_rdata, exp_st);
        chk(tag, "irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, ((exp_st & exp_en) != '0)});
    endtask

    // One clock with the given stimulus; model updated from the requirements.
    task automatic tick(input logic [N-1:0] ev, input logic [N-1:0] lvl,
                        input logic wr, input logic sel, input logic [N-1:0] wd,
                        input string tag);
        logic [N-1:0] set_m;
        ev_pulse = ev; lvl_cond = lvl; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        set_m = ev | (lvl & ~prev_lvl & LVLM);
        if (wr && sel)  exp_st = (exp_st & ~wd) | set_m;
        else            exp_st = exp_st | set_m;
        if (wr && !sel) exp_en = wd;
        prev_lvl = lvl;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset with stimulus applied.
        ev_pulse = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;

        // R2/R6/R8: sweep every source bit against the enable mask.
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] b;
            b = N'(1) << i;
            tick(b, '0, 1'b0, 1'b0, '0, "R2");            // set, enable zero (R6)
            tick('0, '0, 1'b0, 1'b0, '0, "R2");           // stays set
            tick('0, '0, 1'b1, 1'b0, b, "R8");            // enabled -> irq
            tick('0, '0, 1'b1, 1'b0, ~b, "R8");           // all others enabled -> no irq
            tick('0, '0, 1'b1, 1'b1, b, "R4");            // W1C
            tick('0, '0, 1'b1, 1'b0, '0, "R7");
        end

        // R4: partial clear mask.
        tick('1, '0, 1'b0, 1'b0, '0, "R6");
        tick('0, '0, 1'b1, 1'b1, 14'h0F0F, "R4");
        tick('0, '0, 1'b1, 1'b1, 14'h3FFF, "R4");

        // R5: strobe beats a clear of the same bit, neighbour still clears.
        tick(14'h0088, '0, 1'b0, 1'b0, '0, "R5");
        tick(14'h0080, '0, 1'b1, 1'b1, 14'h0088, "R5");
        tick('0, '0, 1'b1, 1'b1, 14'h0080, "R4");

        // R3: level-type bits are edge triggered.
        for (int i = 0; i < 6; i++) begin
            logic [N-1:0] b;
            b = N'(1) << i;
            tick('0, b, 1'b0, 1'b0, '0, "R3");            // rise sets
            tick('0, b, 1'b1, 1'b1, b, "R3");             // clear while held
            tick('0, b, 1'b0, 1'b0, '0, "R3");            // stays clear
            tick('0, '0, 1'b0, 1'b0, '0, "R3");
            tick('0, b, 1'b0, 1'b0, '0, "R3");            // new rise sets again
            tick('0, '0, 1'b1, 1'b1, b, "R3");
        end
        // R3: upper condition bits are ignored.
        tick('0, 14'h3FC0, 1'b0, 1'b0, '0, "R3");
        tick('0, 14'h3FC0, 1'b0, 1'b0, '0, "R3");
        tick('0, '0, 1'b0, 1'b0, '0, "R3");

        // R7/R8: enable patterns and read-back, zero mask masks all.
        tick(14'h2A55, '0, 1'b1, 1'b0, 14'h1234, "R7");
        tick('0, '0, 1'b1, 1'b0, 14'h3FFF, "R8");
        tick('0, '0, 1'b1, 1'b0, 14'h15AA, "R8");
        tick('0, '0, 1'b1, 1'b0, '0, "R8");
        tick('0, '0, 1'b1, 1'b0, 14'h2000, "R8");

        // R1: reset again from a busy state.
        rst_n = 1'b0;
        exp_st = '0; exp_en = '0; prev_lvl = '0;
        @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule